// File: doc/BRIEF.md
# Phase-Slewing Numerically Controlled Oscillator

This block synthesizes a nominal 5 MHz square wave and its 32-bit phase word from a fixed system clock. The nominal frequency is set by a tuning word, and the output runs at the same rate as the reference it is disciplined to. Phase corrections never move the phase word directly. A signed phase request, given in accumulator units (2^32 units per output period), is spread over a programmable number of system-clock cycles. For that many cycles the tuning word is pushed off nominal. The phase therefore slews continuously, and a transmitter driven from the output sees no discontinuity.

Each correction goes through the same single command port, whether an operator asked for it or a control loop produced it. A serial divider splits the request into a per-cycle offset and a remainder. The remainder is folded into the final slew cycle, so the net shift matches the request exactly. At the default width one accumulator unit is far below 1 ns of output phase, so adjustments of 1 ns and finer can be expressed.

Top module: `phase_slew_nco`

## Requirements
- R1: While reset is held, and on release, phase_o is 0, ftw_o equals the nominal tuning word, and busy_o, done_o and cmd_reject_o are 0.
- R2: When no adjustment is running, ftw_o equals the nominal tuning word and phase_o grows by that word on every clock edge.
- R3: An accepted command (cmd_valid_i high while idle, with a nonzero amount and a nonzero cycle count D) raises busy_o after the accepting edge. busy_o then stays high for exactly 33 + D samples: 33 cycles of division followed by D cycles of slew, at the default 32-bit amount.
- R4: During the D slew cycles, ftw_o equals nominal plus Q in the first D-1 cycles and nominal plus Q+R in the last. Q = amount/D truncated toward zero, and R = amount - Q*D carries the sign of the amount. During the division cycles ftw_o stays nominal.
- R5: Once an adjustment ends, phase_o equals the nominal advance since reset plus the sum of all applied amounts, modulo 2^32. This holds for both positive and negative amounts.
- R6: done_o is a one-cycle pulse. It is high in the first cycle in which busy_o is low after an adjustment.
- R7: A command that arrives while busy_o is high is dropped. cmd_reject_o pulses for one cycle after that edge, the running adjustment completes unchanged, and the dropped amount never reaches phase_o.
- R8: A command with a zero amount or a zero cycle count while idle pulses done_o in the next cycle. busy_o stays low, ftw_o stays nominal and phase_o takes no extra shift.
- R9: phase_o wraps modulo 2^32, and clk_out_o is its most significant bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command strobe, one cycle |
| cmd_amount_i | input | 32 | Signed phase shift in accumulator units |
| cmd_cycles_i | input | 16 | Slew duration in clock cycles |
| busy_o | output | 1 | Adjustment in progress |
| done_o | output | 1 | Adjustment finished, one-cycle pulse |
| cmd_reject_o | output | 1 | Command dropped because busy, one-cycle pulse |
| ftw_o | output | 32 | Tuning word in use this cycle |
| phase_o | output | 32 | Phase accumulator |
| clk_out_o | output | 1 | Synthesized square wave (accumulator MSB) |

## Verification
The bench targets the corner cases of the remainder. It uses a remainder of zero, a positive remainder, a negative remainder, a quotient of zero where only the last cycle moves, and a one-cycle slew. A design that drops the remainder or gives it the wrong sign leaves the final phase off by R. A design that places the remainder in the wrong cycle fails the per-cycle tuning trace. Collisions and zero commands are driven too. A design that queues or applies a colliding command, or that starts a slew for a zero request, shows an extra phase shift or a busy window of the wrong length. The bench also follows the accumulator through its 2^32 wrap, which catches any saturating or mis-sized phase arithmetic.

// File: rtl/psn_pkg.sv
package psn_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV  = 2'd1,
    ST_SLEW = 2'd2
  } psn_state_e;
endpackage

// File: rtl/psn_divider.sv
// Restoring serial divider: one quotient bit per cycle, unsigned.
module psn_divider #(
  parameter int unsigned DVD_W = 32,
  parameter int unsigned DVS_W = 16,
  localparam int unsigned CNT_W = $clog2(DVD_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DVD_W-1:0] dividend_i,
  input  logic [DVS_W-1:0] divisor_i,
  output logic             valid_o,
  output logic [DVD_W-1:0] quo_o,
  output logic [DVS_W-1:0] rem_o
);
  logic [DVD_W-1:0] quo_q;
  logic [DVS_W-1:0] rem_q;
  logic [DVS_W-1:0] dvs_q;
  logic [CNT_W-1:0] cnt_q;
  logic             valid_q;
  logic [DVS_W:0]   shifted;
  logic             fits;

  assign shifted = {rem_q, quo_q[DVD_W-1]};
  assign fits    = shifted >= {1'b0, dvs_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_q   <= '0;
      rem_q   <= '0;
      dvs_q   <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else if (start_i) begin
      quo_q   <= dividend_i;
      rem_q   <= '0;
      dvs_q   <= divisor_i;
      cnt_q   <= CNT_W'(DVD_W);
      valid_q <= 1'b0;
    end else if (cnt_q != '0) begin
      if (fits) begin
        rem_q <= DVS_W'(shifted - {1'b0, dvs_q});
        quo_q <= {quo_q[DVD_W-2:0], 1'b1};
      end else begin
        rem_q <= shifted[DVS_W-1:0];
        quo_q <= {quo_q[DVD_W-2:0], 1'b0};
      end
      cnt_q   <= cnt_q - 1'b1;
      valid_q <= (cnt_q == CNT_W'(1));
    end else begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign quo_o   = quo_q;
  assign rem_o   = rem_q;

  a_r4_rem_below_divisor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (rem_o < dvs_q));
endmodule

// File: rtl/psn_slew_ctrl.sv
module psn_slew_ctrl
  import psn_pkg::*;
#(
  parameter int unsigned ACC_W = 32,
  parameter int unsigned AMT_W = 32,
  parameter int unsigned DUR_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cmd_valid_i,
  input  logic signed [AMT_W-1:0] cmd_amount_i,
  input  logic [DUR_W-1:0]        cmd_cycles_i,
  output logic                    div_start_o,
  output logic [AMT_W-1:0]        div_mag_o,
  input  logic                    div_valid_i,
  input  logic [AMT_W-1:0]        div_quo_i,
  input  logic [DUR_W-1:0]        div_rem_i,
  output logic [ACC_W-1:0]        offset_o,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    reject_o
);
  psn_state_e       state_q;
  logic [DUR_W-1:0] left_q;
  logic [DUR_W-1:0] dur_q;
  logic             neg_q;
  logic [ACC_W-1:0] off_q;
  logic [ACC_W-1:0] off_last_q;
  logic             done_q;
  logic             rej_q;
  logic             idle;
  logic             zero_cmd;
  logic             accept;
  logic [ACC_W-1:0] q_ext;
  logic [ACC_W-1:0] r_ext;
  logic [ACC_W-1:0] q_sgn;
  logic [ACC_W-1:0] r_sgn;

  assign idle        = (state_q == ST_IDLE);
  assign zero_cmd    = (cmd_amount_i == '0) || (cmd_cycles_i == '0);
  assign accept      = cmd_valid_i && idle && !zero_cmd;
  assign div_start_o = accept;
  assign div_mag_o   = cmd_amount_i[AMT_W-1] ? AMT_W'(-cmd_amount_i) : AMT_W'(cmd_amount_i);

  assign q_ext = ACC_W'(div_quo_i);
  assign r_ext = ACC_W'(div_rem_i);
  assign q_sgn = neg_q ? (~q_ext + 1'b1) : q_ext;
  assign r_sgn = neg_q ? (~r_ext + 1'b1) : r_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      left_q     <= '0;
      dur_q      <= '0;
      neg_q      <= 1'b0;
      off_q      <= '0;
      off_last_q <= '0;
      done_q     <= 1'b0;
      rej_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      rej_q  <= cmd_valid_i && !idle;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q <= ST_DIV;
            dur_q   <= cmd_cycles_i;
            neg_q   <= cmd_amount_i[AMT_W-1];
          end else if (cmd_valid_i) begin
            done_q <= 1'b1;
          end
        end
        ST_DIV: begin
          if (div_valid_i) begin
            state_q    <= ST_SLEW;
            left_q     <= dur_q;
            off_q      <= q_sgn;
            off_last_q <= q_sgn + r_sgn;
          end
        end
        ST_SLEW: begin
          left_q <= left_q - 1'b1;
          if (left_q == DUR_W'(1)) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    offset_o = '0;
    if (state_q == ST_SLEW) offset_o = (left_q == DUR_W'(1)) ? off_last_q : off_q;
  end

  assign busy_o   = !idle;
  assign done_o   = done_q;
  assign reject_o = rej_q;

  a_r3_slew_count_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SLEW) |-> (left_q != '0));
  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/psn_phase_acc.sv
module psn_phase_acc #(
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] ftw_i,
  output logic [ACC_W-1:0] phase_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_o <= '0;
    else         phase_o <= phase_o + ftw_i;  // modular wrap
  end
endmodule

// File: rtl/phase_slew_nco.sv
module phase_slew_nco #(
  parameter int unsigned ACC_W   = 32,
  parameter int unsigned AMT_W   = 32,
  parameter int unsigned DUR_W   = 16,
  parameter logic [ACC_W-1:0] NOM_FTW = 32'd214748365
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cmd_valid_i,
  input  logic signed [AMT_W-1:0] cmd_amount_i,
  input  logic [DUR_W-1:0]        cmd_cycles_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    cmd_reject_o,
  output logic [ACC_W-1:0]        ftw_o,
  output logic [ACC_W-1:0]        phase_o,
  output logic                    clk_out_o
);
  logic             div_start;
  logic [AMT_W-1:0] div_mag;
  logic             div_valid;
  logic [AMT_W-1:0] div_quo;
  logic [DUR_W-1:0] div_rem;
  logic [ACC_W-1:0] offset;

  psn_slew_ctrl #(.ACC_W(ACC_W), .AMT_W(AMT_W), .DUR_W(DUR_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_amount_i (cmd_amount_i),
    .cmd_cycles_i (cmd_cycles_i),
    .div_start_o  (div_start),
    .div_mag_o    (div_mag),
    .div_valid_i  (div_valid),
    .div_quo_i    (div_quo),
    .div_rem_i    (div_rem),
    .offset_o     (offset),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .reject_o     (cmd_reject_o)
  );

  psn_divider #(.DVD_W(AMT_W), .DVS_W(DUR_W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (div_start),
    .dividend_i (div_mag),
    .divisor_i  (cmd_cycles_i),
    .valid_o    (div_valid),
    .quo_o      (div_quo),
    .rem_o      (div_rem)
  );

  assign ftw_o = NOM_FTW + offset;

  psn_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ftw_i   (ftw_o),
    .phase_o (phase_o)
  );

  assign clk_out_o = phase_o[ACC_W-1];

  a_r2_idle_nominal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (ftw_o == NOM_FTW));
  a_r7_reject_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && busy_o) |=> cmd_reject_o);
  a_r6_done_when_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r8_zero_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !busy_o && (cmd_amount_i == '0 || cmd_cycles_i == '0))
      |=> (!busy_o && done_o));
endmodule

// File: tb/sim_phase_slew_nco.sv
module sim_phase_slew_nco;
  localparam logic [31:0] NOM = 32'd214748365;
  localparam int DIV_LAT = 33;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               cmd_valid = 1'b0;
  logic signed [31:0] cmd_amount = '0;
  logic [15:0]        cmd_cycles = '0;
  logic               busy, done, rej, clk_out;
  logic [31:0]        ftw, phase;

  int          n_chk = 0;
  int          n_bad = 0;
  logic [31:0] cyc = '0;
  logic [31:0] applied = '0;
  int          wd = 0;
  bit          ended = 1'b0;
  logic [31:0] tr [0:511];

  always #5 clk = ~clk;

  phase_slew_nco u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_amount_i(cmd_amount),
    .cmd_cycles_i(cmd_cycles), .busy_o(busy), .done_o(done), .cmd_reject_o(rej),
    .ftw_o(ftw), .phase_o(phase), .clk_out_o(clk_out)
  );

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic finish_sim();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R3: cycles %0d expected below %0d", wd, 150000);
      finish_sim();
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_phase();
    return NOM * cyc + applied;
  endfunction

  task automatic t_reset();
    #1;
    chk(phase == 0 && ftw == NOM, "R1", "phase/ftw in reset", {phase, ftw}, {32'd0, NOM});
    chk({busy, done, rej} == 3'b000, "R1", "flags in reset", 64'({busy, done, rej}), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(phase == exp_phase(), "R1", "phase after release", phase, exp_phase());
  endtask

  task automatic t_idle();
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (phase != exp_phase() || ftw != NOM) break;
    end
    chk(ftw == NOM, "R2", "idle ftw", ftw, NOM);
    chk(phase == exp_phase(), "R2", "idle phase advance", phase, exp_phase());
  endtask

  task automatic t_wrap();
    logic [31:0] prev;
    bit seen = 1'b0;
    prev = phase;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (phase < prev) begin seen = 1'b1; break; end
      prev = phase;
    end
    chk(seen && phase == exp_phase(), "R9", "wrap modulo 2^32", phase, exp_phase());
    chk(clk_out == phase[31], "R9", "clk_out is msb", 64'(clk_out), 64'(phase[31]));
  endtask

  task automatic t_adjust(input logic signed [31:0] amt, input logic [15:0] dur);
    int n;
    int bad;
    int signed d;
    logic signed [31:0] q, r;
    d = int'(dur);
    q = amt / d;
    r = amt % d;
    cmd_amount = amt; cmd_cycles = dur; cmd_valid = 1'b1;
    @(negedge clk); cmd_valid = 1'b0;
    chk(busy == 1'b1, "R3", "busy after accept", 64'(busy), 1);
    n = 0;
    while (busy && n < 500) begin
      tr[n] = ftw; n++;
      @(negedge clk);
    end
    chk(n == DIV_LAT + d, "R3", "busy length", 64'(n), 64'(DIV_LAT + d));
    bad = 0;
    if (n == DIV_LAT + d) begin
      for (int i = 0; i < n; i++) begin
        if (i < DIV_LAT && tr[i] != NOM) bad++;
        else if (i >= DIV_LAT && i < n - 1 && tr[i] != NOM + q) bad++;
        else if (i == n - 1 && tr[i] != NOM + q + r) bad++;
      end
    end
    chk(bad == 0, "R4", "tuning trace", 64'(bad), 0);
    chk(done == 1'b1, "R6", "done at end", 64'(done), 1);
    applied = applied + amt;
    chk(phase == exp_phase(), "R5", "net phase", phase, exp_phase());
    @(negedge clk);
    chk(done == 1'b0, "R6", "done single cycle", 64'(done), 0);
  endtask

  task automatic t_reject();
    cmd_amount = 32'sd500; cmd_cycles = 16'd20; cmd_valid = 1'b1;
    @(negedge clk); cmd_valid = 1'b0;
    repeat (40) @(negedge clk);
    cmd_amount = 32'sd77777; cmd_cycles = 16'd3; cmd_valid = 1'b1;
    @(negedge clk); cmd_valid = 1'b0;
    chk(rej == 1'b1, "R7", "reject pulse", 64'(rej), 1);
    @(negedge clk);
    chk(rej == 1'b0, "R7", "reject single cycle", 64'(rej), 0);
    while (busy) @(negedge clk);
    applied = applied + 32'd500;
    chk(phase == exp_phase(), "R7", "only first amount applied", phase, exp_phase());
    repeat (60) @(negedge clk);
    chk(!busy && phase == exp_phase(), "R7", "no queued command", phase, exp_phase());
  endtask

  task automatic t_zero(input logic signed [31:0] amt, input logic [15:0] dur);
    cmd_amount = amt; cmd_cycles = dur; cmd_valid = 1'b1;
    @(negedge clk); cmd_valid = 1'b0;
    chk(done == 1'b1 && busy == 1'b0, "R8", "zero cmd done", 64'({done, busy}), 64'(2'b10));
    chk(ftw == NOM, "R8", "zero cmd ftw", ftw, NOM);
    repeat (40) @(negedge clk);
    chk(phase == exp_phase() && !busy, "R8", "zero cmd no shift", phase, exp_phase());
  endtask

  initial begin
    t_reset();
    t_idle();
    t_wrap();
    t_adjust(32'sd1000, 16'd10);
    t_adjust(32'sd1003, 16'd7);
    t_adjust(-32'sd1003, 16'd7);
    t_adjust(32'sd5, 16'd10);
    t_adjust(-32'sd4321, 16'd1);
    t_adjust(32'sh7fffffff, 16'd3);
    t_adjust(-32'sd2147483648, 16'd64);
    t_reject();
    t_zero(32'sd0, 16'd5);
    t_zero(32'sd99, 16'd0);
    t_wrap();
    finish_sim();
  end
endmodule